// File: doc/BRIEF.md
# Synchronous Serial Port with Residual-Byte Pop

This block is a full-duplex synchronous serial port for use as either clock master or clock slave. Software reaches it through a small register window. A 32-bit data location takes writes and gives reads. Each write places a 16-bit entry into an eight-deep transmit queue. The serial engine sends that entry as two bytes, high byte first and MSB first. Received 16-bit entries collect in an eight-deep receive queue, and a word read takes them out. In master mode the port makes its own serial clock from a programmable divider. It also drives a one-bit-period frame-sync ahead of every entry. In slave mode it passes the external clock, frame-sync and data through a two-flop synchronizer and samples them on the rising edge.

A second, write-only location acts as a pop strobe. It moves whatever the receive shifter holds into the receive queue, so a trailing odd byte can be read. Two flags report residual conditions. The first says that the last pop carried a partial entry. The second says that a slave frame was cut off by a new frame-sync before its word was complete.

The engine is a four-state machine. IDLE waits for work: a non-empty transmit queue in master mode, or a sampled frame-sync in slave mode. FSYNC (master only) drives the frame-sync for one serial clock period. SHIFT moves 16 bits. From SHIFT a master returns to FSYNC if more entries are queued and to IDLE if not. A slave leaves SHIFT for IDLE after the 16th bit or on a pop. It goes to PARK when a frame-sync arrives in the middle of a word. PARK ignores the serial clock and returns to IDLE on a pop.

Top module: `ssp_residual_port`

## Requirements
- R1: A word write (bus_size = 2) to word offset 0 pushes bus_wdata[15:0] into the transmit queue. Bits 31:16 are discarded.
- R2: A byte (bus_size = 0) or halfword (bus_size = 1) access to offset 0 is ignored. Such a write pushes nothing, and such a read pops nothing and returns zero.
- R3: The transmit queue holds 8 entries and tx_full is high while it holds 8. A word write to a full queue is dropped and sets tx_ovf, which stays set until reset.
- R4: A word read of offset 0 returns {16'h0000, oldest received entry} and removes that entry. A read of an empty queue returns zero. bus_rdata[31:16] is always zero.
- R5: In master mode, a non-empty transmit queue starts a transfer while the engine is idle. fs_out is high for one full sclk_out period before the first bit. Each entry then shifts out as 16 bits MSB first, and queued entries follow back to back, each with its own frame-sync.
- R6: In master mode sclk_out has a period of 2*(cfg_div+1) clock cycles and idles low. sdo changes after falling edges and sdi is sampled on rising edges. In slave mode sclk_out and fs_out stay low.
- R7: In slave mode, sclk_in, fs_in and sdi pass through two synchronizing flops. fs_in seen high at a rising sclk_in edge starts a word. The next 16 rising edges shift sdi into an entry that is pushed to the receive queue. The transmit head (zero if the queue is empty) is presented on sdo MSB first.
- R8: A write to word offset 1 (the pop strobe, any size, data ignored) while the receive shifter holds 1 to 15 bits pushes those bits right-aligned with zero fill. The same write sets resid_valid, clears resid_frame and returns a slave engine to IDLE.
- R9: A pop while the receive shifter holds no bits pushes nothing and clears resid_valid.
- R10: In slave mode, a frame-sync sampled while the receive shifter holds 1 to 15 bits sets resid_frame. The engine then parks, ignores serial clock edges and keeps those bits until a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word offset: 0 data, 1 pop strobe |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_re is high |
| cfg_master | input | 1 | 1 selects master mode, 0 slave |
| cfg_div | input | DIV_W | Master half-period in clock cycles, minus one |
| sclk_out | output | 1 | Serial clock driven in master mode |
| fs_out | output | 1 | Frame-sync driven in master mode |
| sdo | output | 1 | Serial data out |
| sclk_in | input | 1 | External serial clock for slave mode |
| fs_in | input | 1 | External frame-sync for slave mode |
| sdi | input | 1 | Serial data in |
| tx_full | output | 1 | Transmit queue holds 8 entries |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_avail | output | 1 | Receive queue is not empty |
| resid_valid | output | 1 | Last pop pushed a partial entry |
| resid_frame | output | 1 | A slave frame ended inside a word |

## Verification
The checker watches several rules on every cycle. It confirms that the upper read half is always zero and that a write to a full queue is followed by a sticky overflow. It confirms that resid_valid rises only after a pop and that a pop always leaves resid_frame clear. It also confirms that resid_frame rises only in slave mode, that the serial outputs stay quiet in slave mode, and that a frame-sync never starts while the clock is high. Only the bench scenarios can show the bit order on the wire, the measured clock period, the contents of pushed and residual entries, the dropping of the ninth queued entry, and the ignoring of serial edges while parked.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int BUS_W   = 32;
    localparam int ENTRY_W = 16;
    localparam int CNT_W   = $clog2(ENTRY_W) + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FSYNC = 2'd1,
        ST_SHIFT = 2'd2,
        ST_PARK  = 2'd3
    } eng_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign rdata = mem[rp[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (wr && !full)  wp <= wp + 1'b1;
            if (rd && !empty) rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr && !full) mem[wp[AW-1:0]] <= wdata;
    end
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             tick;

    assign tick = run && (cnt_q == div);
    assign rise = tick && !sclk;
    assign fall = tick && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            sclk  <= ~sclk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ssp_slave_sync.sv
module ssp_slave_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic fs_in,
    input  logic sdi,
    output logic rise,
    output logic fall,
    output logic fs_smp,
    output logic sdi_smp
);
    logic [STAGES:0]   ck_sr;
    logic [STAGES-1:0] fs_sr;
    logic [STAGES-1:0] d_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_sr <= '0;
            fs_sr <= '0;
            d_sr  <= '0;
        end else begin
            ck_sr <= {ck_sr[STAGES-1:0], sclk_in};
            fs_sr <= {fs_sr[STAGES-2:0], fs_in};
            d_sr  <= {d_sr[STAGES-2:0], sdi};
        end
    end

    assign rise    =  ck_sr[STAGES-1] && !ck_sr[STAGES];
    assign fall    = !ck_sr[STAGES-1] &&  ck_sr[STAGES];
    assign fs_smp  = fs_sr[STAGES-1];
    assign sdi_smp = d_sr[STAGES-1];
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
    import ssp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               master,
    input  logic               rise,
    input  logic               fall,
    input  logic               fs_smp,
    input  logic               sdi_smp,
    input  logic               tx_empty,
    input  logic [ENTRY_W-1:0] tx_head,
    input  logic               pop_req,
    output logic               tx_rd,
    output logic               rx_wr,
    output logic [ENTRY_W-1:0] rx_wdata,
    output logic               sdo,
    output logic               fs_out,
    output logic               run,
    output logic               resid_valid,
    output logic               resid_frame
);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(ENTRY_W);
    localparam logic [CNT_W-1:0] LAST_M1 = CNT_W'(ENTRY_W - 1);

    eng_state_e         st_q, st_d;
    logic [ENTRY_W-1:0] tx_sh, rx_sh;
    logic [CNT_W-1:0]   bcnt, rcnt;
    logic               in_shift, load, sample, shift_out;
    logic               m_end, s_end, s_break, rx_partial;

    // event decode shared by state and datapath
    always_comb begin
        in_shift   = (st_q == ST_SHIFT);
        rx_partial = (rcnt != '0);
        m_end      = in_shift && master && fall && (bcnt == LAST);
        s_break    = in_shift && !master && rise && fs_smp && rx_partial;
        s_end      = in_shift && !master && rise && !fs_smp && (bcnt == LAST_M1);
        load       = ((st_q == ST_IDLE) && master && !tx_empty)
                   || (m_end && !tx_empty)
                   || ((st_q == ST_IDLE) && !master && rise && fs_smp);
        sample     = in_shift && rise && (master || !fs_smp) && !pop_req;
        shift_out  = in_shift && fall && (bcnt != '0) && (bcnt != LAST);
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (master && !tx_empty)              st_d = ST_FSYNC;
                else if (!master && rise && fs_smp)   st_d = ST_SHIFT;
            end
            ST_FSYNC: begin
                if (fall) st_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (pop_req && !master) st_d = ST_IDLE;
                else if (m_end)         st_d = tx_empty ? ST_IDLE : ST_FSYNC;
                else if (s_break)       st_d = ST_PARK;
                else if (s_end)         st_d = ST_IDLE;
            end
            ST_PARK: begin
                if (pop_req) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh       <= '0;
            rx_sh       <= '0;
            bcnt        <= '0;
            rcnt        <= '0;
            resid_valid <= 1'b0;
            resid_frame <= 1'b0;
        end else begin
            if (load)           tx_sh <= tx_empty ? '0 : tx_head;
            else if (shift_out) tx_sh <= tx_sh << 1;

            if (load)        bcnt <= '0;
            else if (sample) bcnt <= bcnt + 1'b1;

            if (pop_req) begin
                rx_sh <= '0;
                rcnt  <= '0;
            end else if (sample) begin
                if (rcnt == LAST_M1) begin
                    rx_sh <= '0;
                    rcnt  <= '0;
                end else begin
                    rx_sh <= {rx_sh[ENTRY_W-2:0], sdi_smp};
                    rcnt  <= rcnt + 1'b1;
                end
            end

            if (pop_req) resid_valid <= rx_partial;

            if (pop_req)      resid_frame <= 1'b0;
            else if (s_break) resid_frame <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        sdo      = tx_sh[ENTRY_W-1];
        fs_out   = (st_q == ST_FSYNC);
        run      = master && ((st_q == ST_FSYNC) || (st_q == ST_SHIFT));
        tx_rd    = load && !tx_empty;
        rx_wr    = pop_req ? rx_partial : (sample && (rcnt == LAST_M1));
        rx_wdata = pop_req ? rx_sh : {rx_sh[ENTRY_W-2:0], sdi_smp};
    end
endmodule

// File: rtl/ssp_residual_port.sv
module ssp_residual_port
    import ssp_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DEPTH    = 8,
    parameter int DIV_W    = 8,
    parameter int SYNC_N   = 2,
    parameter int DATA_OFS = 0,
    parameter int POP_OFS  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              cfg_master,
    input  logic [DIV_W-1:0]  cfg_div,
    output logic              sclk_out,
    output logic              fs_out,
    output logic              sdo,
    input  logic              sclk_in,
    input  logic              fs_in,
    input  logic              sdi,
    output logic              tx_full,
    output logic              tx_ovf,
    output logic              rx_avail,
    output logic              resid_valid,
    output logic              resid_frame
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] A_POP  = ADDR_W'(POP_OFS);

    logic               word_acc, wr_data, rd_data, pop_req;
    logic               tx_empty, tx_rd, rx_empty, rx_full, rx_wr, rx_rd;
    logic [ENTRY_W-1:0] tx_head, rx_head, rx_wdata;
    logic               m_rise, m_fall, s_rise, s_fall, s_fs, s_sdi;
    logic               e_rise, e_fall, e_sdi, run;

    // register decode
    assign word_acc = (bus_size == SZ_WORD);
    assign wr_data  = bus_we && (bus_addr == A_DATA) && word_acc;
    assign rd_data  = bus_re && (bus_addr == A_DATA) && word_acc;
    assign pop_req  = bus_we && (bus_addr == A_POP);
    assign rx_rd    = rd_data && !rx_empty;
    assign bus_rdata = rx_rd ? {{(BUS_W-ENTRY_W){1'b0}}, rx_head} : '0;
    assign rx_avail = !rx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  tx_ovf <= 1'b0;
        else if (wr_data && tx_full) tx_ovf <= 1'b1;
    end

    ssp_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) i_txq (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_data), .wdata(bus_wdata[ENTRY_W-1:0]),
        .rd(tx_rd), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    ssp_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) i_rxq (
        .clk(clk), .rst_n(rst_n),
        .wr(rx_wr), .wdata(rx_wdata),
        .rd(rx_rd), .rdata(rx_head),
        .full(rx_full), .empty(rx_empty)
    );

    ssp_clkgen #(.DIV_W(DIV_W)) i_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .div(cfg_div),
        .sclk(sclk_out), .rise(m_rise), .fall(m_fall)
    );

    ssp_slave_sync #(.STAGES(SYNC_N)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_in(sclk_in), .fs_in(fs_in), .sdi(sdi),
        .rise(s_rise), .fall(s_fall), .fs_smp(s_fs), .sdi_smp(s_sdi)
    );

    assign e_rise = cfg_master ? m_rise : s_rise;
    assign e_fall = cfg_master ? m_fall : s_fall;
    assign e_sdi  = cfg_master ? sdi    : s_sdi;

    ssp_engine i_engine (
        .clk(clk), .rst_n(rst_n), .master(cfg_master),
        .rise(e_rise), .fall(e_fall), .fs_smp(s_fs), .sdi_smp(e_sdi),
        .tx_empty(tx_empty), .tx_head(tx_head), .pop_req(pop_req),
        .tx_rd(tx_rd), .rx_wr(rx_wr), .rx_wdata(rx_wdata),
        .sdo(sdo), .fs_out(fs_out), .run(run),
        .resid_valid(resid_valid), .resid_frame(resid_frame)
    );

    // receive entries arriving at a full queue are dropped inside the queue
    logic unused_ok;
    assign unused_ok = rx_full;
endmodule

// File: rtl/ssp_residual_port_chk.sv
module ssp_residual_port_chk #(
    parameter int ADDR_W   = 4,
    parameter int DATA_OFS = 0,
    parameter int POP_OFS  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [31:0]       bus_rdata,
    input logic              cfg_master,
    input logic              sclk_out,
    input logic              fs_out,
    input logic              tx_full,
    input logic              tx_ovf,
    input logic              resid_valid,
    input logic              resid_frame
);
    logic wr_word, pop_wr;
    assign wr_word = bus_we && (bus_addr == ADDR_W'(DATA_OFS)) && (bus_size == 2'd2);
    assign pop_wr  = bus_we && (bus_addr == ADDR_W'(POP_OFS));

    p_rdata_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0000);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word && tx_full) |=> tx_ovf);

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |=> tx_ovf);

    p_slave_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> (!sclk_out && !fs_out));

    p_fs_clock_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_out) |-> !sclk_out);

    p_resid_from_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resid_valid) |-> $past(pop_wr));

    p_pop_clears_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_wr |=> !resid_frame);

    p_frame_slave_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resid_frame) |-> !cfg_master);
endmodule

bind ssp_residual_port ssp_residual_port_chk #(
    .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .POP_OFS(POP_OFS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_rdata(bus_rdata), .cfg_master(cfg_master),
    .sclk_out(sclk_out), .fs_out(fs_out), .tx_full(tx_full), .tx_ovf(tx_ovf),
    .resid_valid(resid_valid), .resid_frame(resid_frame)
);

// File: tb/test_ssp_residual_port.sv
`timescale 1ns/1ps
module test_ssp_residual_port;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cfg_master = 1'b1;
    logic [7:0]  cfg_div = 8'd2;
    logic        sclk_out, fs_out, sdo;
    logic        sclk_in = 1'b0, fs_in = 1'b0, sdi_drv = 1'b0;
    logic        sdi;
    logic        tx_full, tx_ovf, rx_avail, resid_valid, resid_frame;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sdi = cfg_master ? sdo : sdi_drv;

    ssp_residual_port i_ssp_residual_port (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cfg_master(cfg_master), .cfg_div(cfg_div),
        .sclk_out(sclk_out), .fs_out(fs_out), .sdo(sdo),
        .sclk_in(sclk_in), .fs_in(fs_in), .sdi(sdi),
        .tx_full(tx_full), .tx_ovf(tx_ovf), .rx_avail(rx_avail),
        .resid_valid(resid_valid), .resid_frame(resid_frame)
    );

    // master-side wire monitor
    logic [15:0] cap;
    int          cap_bits = 0;
    bit          fs_seen = 1'b0;
    logic [15:0] cap_words [4];
    int          cap_n = 0;
    time         t_prev = 0, t_last = 0;

    always @(posedge sclk_out) begin
        t_prev = t_last;
        t_last = $time;
        if (fs_out) begin
            fs_seen  = 1'b1;
            cap_bits = 0;
        end else if (fs_seen) begin
            cap = {cap[14:0], sdo};
            cap_bits++;
            if (cap_bits == 16) begin
                if (cap_n < 4) cap_words[cap_n] = cap;
                cap_n++;
                fs_seen = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_size = 2'd2;
    endtask

    task automatic bus_read(input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = 4'd0; bus_size = sz;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0; bus_size = 2'd2;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_caps(input int n);
        for (int i = 0; i < 3000 && cap_n < n; i++) @(negedge clk);
        idle(10);
    endtask

    task automatic s_edge_hi;
        repeat (HALF) @(negedge clk);
        sclk_in = 1'b1;
    endtask

    task automatic s_edge_lo;
        repeat (HALF) @(negedge clk);
        sclk_in = 1'b0;
    endtask

    task automatic s_fs;
        fs_in = 1'b1; sdi_drv = 1'b0;
        s_edge_hi();
        s_edge_lo();
        fs_in = 1'b0;
    endtask

    task automatic s_bits(input int n, input logic [15:0] d, output logic [15:0] so);
        so = '0;
        for (int i = n - 1; i >= 0; i--) begin
            sdi_drv = d[i];
            repeat (HALF) @(negedge clk);
            so = {so[14:0], sdo};
            sclk_in = 1'b1;
            s_edge_lo();
        end
    endtask

    task automatic t_reset;
        chk("R3 tx_full after reset", 32'(tx_full), 32'd0);
        chk("R3 tx_ovf after reset", 32'(tx_ovf), 32'd0);
        chk("R6 sclk_out idle after reset", 32'(sclk_out), 32'd0);
        chk("R8 resid flags after reset", {30'd0, resid_valid, resid_frame}, 32'd0);
    endtask

    task automatic t_master_single;
        logic [31:0] r;
        cfg_master = 1'b1; cfg_div = 8'd2;
        bus_write(4'd0, 2'd2, 32'hABCD_1234);
        wait_caps(1);
        chk("R5 master wire word MSB first", 32'(cap_words[0]), 32'h0000_1234);
        chk("R6 sclk period 2*(div+1)", 32'((t_last - t_prev) / 20), 32'd6);
        chk("R6 sclk idles low", 32'(sclk_out), 32'd0);
        bus_read(2'd2, r);
        chk("R1 low half only, loopback read", r, 32'h0000_1234);
    endtask

    task automatic t_master_pair;
        logic [31:0] r;
        int base;
        base = cap_n;
        cfg_div = 8'd0;
        bus_write(4'd0, 2'd2, 32'h0000_00F0);
        bus_write(4'd0, 2'd2, 32'h1234_5A0F);
        wait_caps(base + 2);
        chk("R5 back-to-back first", 32'(cap_words[base]), 32'h0000_00F0);
        chk("R5 back-to-back second", 32'(cap_words[base + 1]), 32'h0000_5A0F);
        bus_read(2'd2, r);
        chk("R4 read oldest first", r, 32'h0000_00F0);
        bus_read(2'd2, r);
        chk("R4 read second", r, 32'h0000_5A0F);
        bus_read(2'd2, r);
        chk("R4 empty read returns zero", r, 32'h0);
    endtask

    task automatic t_size_ignored;
        int base;
        base = cap_n;
        bus_write(4'd0, 2'd0, 32'h0000_7777);
        bus_write(4'd0, 2'd1, 32'h0000_6666);
        idle(200);
        chk("R2 sub-word write starts nothing", 32'(cap_n - base), 32'd0);
        chk("R2 sub-word write pushes nothing", 32'(rx_avail), 32'd0);
    endtask

    task automatic t_slave_word;
        logic [15:0] so;
        logic [31:0] r;
        cfg_master = 1'b0;
        idle(4);
        bus_write(4'd0, 2'd2, 32'h0000_C3A5);
        idle(20);
        chk("R6 slave keeps fs_out low", 32'(fs_out), 32'd0);
        s_fs();
        s_bits(16, 16'h5AF0, so);
        idle(10);
        chk("R7 slave sdo MSB first", 32'(so), 32'h0000_C3A5);
        bus_read(2'd1, r);
        chk("R2 halfword read returns zero", r, 32'h0);
        chk("R2 halfword read pops nothing", 32'(rx_avail), 32'd1);
        bus_read(2'd2, r);
        chk("R7 slave received word", r, 32'h0000_5AF0);
    endtask

    task automatic t_pop_partial;
        logic [15:0] so;
        logic [31:0] r;
        s_fs();
        s_bits(8, 16'h00A5, so);
        idle(10);
        chk("R8 partial not pushed before pop", 32'(rx_avail), 32'd0);
        bus_write(4'd1, 2'd2, 32'hFFFF_FFFF);
        idle(2);
        chk("R8 resid_valid after partial pop", 32'(resid_valid), 32'd1);
        bus_read(2'd2, r);
        chk("R8 residual byte right-aligned", r, 32'h0000_00A5);
    endtask

    task automatic t_pop_empty;
        bus_write(4'd1, 2'd2, 32'h0);
        idle(2);
        chk("R9 empty pop clears resid_valid", 32'(resid_valid), 32'd0);
        chk("R9 empty pop pushes nothing", 32'(rx_avail), 32'd0);
    endtask

    task automatic t_resid_frame;
        logic [15:0] so;
        logic [31:0] r;
        s_fs();
        s_bits(8, 16'h003C, so);
        s_fs();
        idle(4);
        chk("R10 resid_frame on mid-word sync", 32'(resid_frame), 32'd1);
        s_bits(8, 16'h00FF, so);
        idle(10);
        chk("R10 parked engine pushes nothing", 32'(rx_avail), 32'd0);
        bus_write(4'd1, 2'd0, 32'h1234_5678);
        idle(2);
        chk("R8 pop clears resid_frame", 32'(resid_frame), 32'd0);
        bus_read(2'd2, r);
        chk("R10 parked bits kept for pop", r, 32'h0000_003C);
    endtask

    task automatic t_overflow;
        logic [15:0] so;
        for (int k = 0; k < 8; k++) bus_write(4'd0, 2'd2, 32'h0000_1000 + 32'(k));
        idle(2);
        chk("R3 tx_full at 8 entries", 32'(tx_full), 32'd1);
        chk("R3 no overflow yet", 32'(tx_ovf), 32'd0);
        bus_write(4'd0, 2'd2, 32'h0000_9999);
        idle(2);
        chk("R3 overflow flag set", 32'(tx_ovf), 32'd1);
        for (int k = 0; k < 8; k++) begin
            s_fs();
            s_bits(16, 16'h0000, so);
            if (k == 0) chk("R3 first queued entry", 32'(so), 32'h0000_1000);
        end
        chk("R3 eighth entry kept", 32'(so), 32'h0000_1007);
        s_fs();
        s_bits(16, 16'h0000, so);
        chk("R3 ninth entry dropped", 32'(so), 32'h0);
        chk("R3 overflow sticky", 32'(tx_ovf), 32'd1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        idle(3);
        t_reset();
        t_master_single();
        t_master_pair();
        t_size_ignored();
        t_slave_word();
        t_pop_partial();
        t_pop_empty();
        t_resid_frame();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule